// File: doc/BRIEF.md
# Paged 48-Line Open-Drain Digital I/O with Edge Interrupts

This block serves 48 open-drain digital lines arranged as six 8-bit ports, plus interrupt logic for the lower 24 lines. A host reaches it through a register index, write data and a write strobe. Read data follows the index combinationally.

Register indices 0 to 5 are the port registers. Writing a 1 to a port bit makes the block sink that pin low. Writing a 0 releases the pin, and an external pull-up then holds it high. Reading a port returns the inverted level of its pins after a two-flop synchronizer. Index 6 is an interrupt summary. Index 7 holds a page selector and per-port write locks. Indices 8 to 10 are a window, one byte per interrupt-capable port. The current page decides what the window shows: edge polarity, interrupt enable or latched edge flags.

Each interrupt-capable line can watch for either a rising or a falling edge of its synchronized pin level. A detected edge on an enabled line latches a flag. The interrupt output is high while any flag is set. Software clears flags by writing zeros into the flag page.

Top module: `dio48_port_block`

## Requirements
- R1: After reset, no pin is sunk, `irq_o` is low, and the page/lock register, polarity, enable and flag registers all read 0.
- R2: A write to a port register (index 0..5, bit b of port p is line 8p+b) sets `pin_sink_o` for each line to the written bit. A 1 sinks the pin. `pin_sink_o` changes only on such a write.
- R3: Reading index 0..5 returns the inverse of the pin levels, taken after a two-flop synchronizer. A pin held low reads 1.
- R4: Index 7 holds the page in bits 7:6 and a lock bit per port in bits 5:0, and reads back as written. A port register write is ignored while that port's lock bit is 1.
- R5: Indices 8..10 map to ports 0..2. They show polarity on page 1, enable on page 2 and edge flags on page 3. On page 0 they read 0 and writes to them are ignored.
- R6: For an enabled line, polarity 1 catches a rising pin level and 0 catches a falling one. The flag sets on the third clock edge after the pin changes. Lines whose enable bit is 0 never set a flag.
- R7: Lines 24..47 never set a flag or raise the interrupt.
- R8: Index 6 bit k (k = 0..2) is the OR of port k's flags. Bits 7:3 read 0.
- R9: `irq_o` is high exactly when at least one flag is set.
- R10: A write to the flag page clears each flag whose written bit is 0 and keeps each flag whose written bit is 1.
- R11: An edge detected in the same cycle as a clearing write to its flag leaves that flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 4 | Register index |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the indexed register |
| pin_level_i | input | 48 | Sensed pin levels |
| pin_sink_o | output | 48 | 1 sinks the pin low; 0 leaves it released |
| irq_o | output | 1 | Interrupt, OR of all edge flags |

## Verification
The assertions check four things on every cycle:
- the sink outputs hold between port writes;
- a write to a locked port leaves its lines unchanged;
- every rise of the interrupt follows a detected edge;
- a detected edge always leaves the interrupt high in the next cycle, even when a clearing write lands at the same time.

Other behaviour shows only in the bench scenarios. That covers the page window contents, the two edge polarities, the three-cycle flag latency, the silence of the upper lines and disabled lines, and the keep-or-clear rule for flag writes. In each case the bench sees the result through register reads or the interrupt pin.

// File: rtl/dio48_pkg.sv
package dio48_pkg;
  typedef enum logic [1:0] {
    PG_NONE  = 2'd0,
    PG_POL   = 2'd1,
    PG_ENAB  = 2'd2,
    PG_IDENT = 2'd3
  } page_e;
endpackage

// File: rtl/dio48_sync.sv
// Two-flop synchronizer for the sensed pin levels; idles high (pull-up).
module dio48_sync #(
  parameter int W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, meta_d;
  logic [W-1:0] stab_q, stab_d;

  always_comb begin
    meta_d = d_i;
    stab_d = meta_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '1;
      stab_q <= '1;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/dio48_out_bank.sv
// Per-port sink registers with lock gating.
module dio48_out_bank #(
  parameter int NUM_PORTS = 6,
  parameter int PORT_W    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PORTS-1:0]        wr_sel_i,
  input  logic [NUM_PORTS-1:0]        lock_i,
  input  logic [PORT_W-1:0]           wdata_i,
  output logic [NUM_PORTS*PORT_W-1:0] sink_o
);
  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [PORT_W-1:0] sink_q, sink_d;
      logic              load;

      always_comb begin
        load   = wr_sel_i[p] & ~lock_i[p];
        sink_d = load ? wdata_i : sink_q;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sink_q <= '0;
        else         sink_q <= sink_d;
      end

      assign sink_o[p*PORT_W +: PORT_W] = sink_q;
    end
  endgenerate
endmodule

// File: rtl/dio48_irq_bank.sv
// Polarity, enable and edge-flag registers for the interrupt-capable ports.
module dio48_irq_bank #(
  parameter int IRQ_PORTS = 3,
  parameter int PORT_W    = 8,
  localparam int IRQ_LINES = IRQ_PORTS * PORT_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [IRQ_LINES-1:0] lvl_i,
  input  logic [IRQ_PORTS-1:0] wr_pol_i,
  input  logic [IRQ_PORTS-1:0] wr_enab_i,
  input  logic [IRQ_PORTS-1:0] wr_ident_i,
  input  logic [PORT_W-1:0]    wdata_i,
  output logic [IRQ_LINES-1:0] pol_o,
  output logic [IRQ_LINES-1:0] enab_o,
  output logic [IRQ_LINES-1:0] ident_o,
  output logic [IRQ_LINES-1:0] hit_o,
  output logic [IRQ_PORTS-1:0] pend_o,
  output logic                 irq_o
);
  logic [IRQ_LINES-1:0] prev_q, prev_d;
  logic [IRQ_LINES-1:0] pol_q, pol_d;
  logic [IRQ_LINES-1:0] enab_q, enab_d;
  logic [IRQ_LINES-1:0] ident_q, ident_d;
  logic [IRQ_LINES-1:0] rise, fall, hit;

  always_comb begin
    prev_d = lvl_i;
    rise   = lvl_i & ~prev_q;
    fall   = ~lvl_i & prev_q;
    hit    = enab_q & ((pol_q & rise) | (~pol_q & fall));
    pol_d   = pol_q;
    enab_d  = enab_q;
    ident_d = ident_q;
    for (int k = 0; k < IRQ_PORTS; k++) begin
      if (wr_pol_i[k])  pol_d[k*PORT_W +: PORT_W]  = wdata_i;
      if (wr_enab_i[k]) enab_d[k*PORT_W +: PORT_W] = wdata_i;
      if (wr_ident_i[k])
        ident_d[k*PORT_W +: PORT_W] = ident_q[k*PORT_W +: PORT_W] & wdata_i;
    end
    // a fresh edge outranks a clearing write
    ident_d = ident_d | hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '1;
      pol_q   <= '0;
      enab_q  <= '0;
      ident_q <= '0;
    end else begin
      prev_q  <= prev_d;
      pol_q   <= pol_d;
      enab_q  <= enab_d;
      ident_q <= ident_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < IRQ_PORTS; g++) begin : g_pend
      assign pend_o[g] = |ident_q[g*PORT_W +: PORT_W];
    end
  endgenerate

  assign pol_o   = pol_q;
  assign enab_o  = enab_q;
  assign ident_o = ident_q;
  assign hit_o   = hit;
  assign irq_o   = |ident_q;
endmodule

// File: rtl/dio48_port_block.sv
// Top: register decode, page/lock register, read mux.
// The page/lock register is exactly PORT_W = NUM_PORTS + 2 bits wide.
module dio48_port_block
  import dio48_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int IRQ_PORTS = 3,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_wr_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [PORT_W-1:0]           bus_wdata_i,
  output logic [PORT_W-1:0]           bus_rdata_o,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_level_i,
  output logic [NUM_PORTS*PORT_W-1:0] pin_sink_o,
  output logic                        irq_o
);
  localparam int LINES     = NUM_PORTS * PORT_W;
  localparam int IRQ_LINES = IRQ_PORTS * PORT_W;
  localparam logic [ADDR_W-1:0] IDX_PEND  = ADDR_W'(NUM_PORTS);
  localparam logic [ADDR_W-1:0] IDX_PGLK  = ADDR_W'(NUM_PORTS + 1);
  localparam int                IDX_PAGED = NUM_PORTS + 2;

  page_e                page_q, page_d;
  logic [NUM_PORTS-1:0] lock_q, lock_d;
  logic [NUM_PORTS-1:0] port_wr;
  logic [IRQ_PORTS-1:0] paged_wr, wr_pol, wr_enab, wr_ident;
  logic [LINES-1:0]     lvl;
  logic [IRQ_LINES-1:0] pol, enab, ident, hit;
  logic [IRQ_PORTS-1:0] pend;

  dio48_sync #(.W(LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_level_i),
    .q_o    (lvl)
  );

  // write decode
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++)
      port_wr[p] = bus_wr_i && (bus_addr_i == ADDR_W'(p));
    for (int k = 0; k < IRQ_PORTS; k++)
      paged_wr[k] = bus_wr_i && (bus_addr_i == ADDR_W'(IDX_PAGED + k));
    wr_pol   = (page_q == PG_POL)   ? paged_wr : '0;
    wr_enab  = (page_q == PG_ENAB)  ? paged_wr : '0;
    wr_ident = (page_q == PG_IDENT) ? paged_wr : '0;
  end

  // page/lock register next state
  always_comb begin
    page_d = page_q;
    lock_d = lock_q;
    if (bus_wr_i && bus_addr_i == IDX_PGLK) begin
      page_d = page_e'(bus_wdata_i[PORT_W-1 -: 2]);
      lock_d = bus_wdata_i[NUM_PORTS-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= PG_NONE;
      lock_q <= '0;
    end else begin
      page_q <= page_d;
      lock_q <= lock_d;
    end
  end

  dio48_out_bank #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_sel_i (port_wr),
    .lock_i   (lock_q),
    .wdata_i  (bus_wdata_i),
    .sink_o   (pin_sink_o)
  );

  dio48_irq_bank #(.IRQ_PORTS(IRQ_PORTS), .PORT_W(PORT_W)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_i      (lvl[IRQ_LINES-1:0]),
    .wr_pol_i   (wr_pol),
    .wr_enab_i  (wr_enab),
    .wr_ident_i (wr_ident),
    .wdata_i    (bus_wdata_i),
    .pol_o      (pol),
    .enab_o     (enab),
    .ident_o    (ident),
    .hit_o      (hit),
    .pend_o     (pend),
    .irq_o      (irq_o)
  );

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (bus_addr_i == ADDR_W'(p))
        bus_rdata_o = ~lvl[p*PORT_W +: PORT_W];
    if (bus_addr_i == IDX_PEND)
      bus_rdata_o = PORT_W'(pend);
    if (bus_addr_i == IDX_PGLK)
      bus_rdata_o = {page_q, lock_q};
    for (int k = 0; k < IRQ_PORTS; k++)
      if (bus_addr_i == ADDR_W'(IDX_PAGED + k)) begin
        case (page_q)
          PG_POL:   bus_rdata_o = pol[k*PORT_W +: PORT_W];
          PG_ENAB:  bus_rdata_o = enab[k*PORT_W +: PORT_W];
          PG_IDENT: bus_rdata_o = ident[k*PORT_W +: PORT_W];
          default:  bus_rdata_o = '0;
        endcase
      end
  end
endmodule

// File: rtl/dio48_port_chk.sv
module dio48_port_chk #(
  parameter int NUM_PORTS = 6,
  parameter int IRQ_PORTS = 3,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 4
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          bus_wr_i,
  input logic [ADDR_W-1:0]             bus_addr_i,
  input logic [NUM_PORTS*PORT_W-1:0]   pin_sink_o,
  input logic [NUM_PORTS-1:0]          lock_q,
  input logic [IRQ_PORTS*PORT_W-1:0]   hit,
  input logic                          irq_o
);
  // R2: sink outputs only move on a port write
  assert_drive_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_i && bus_addr_i < ADDR_W'(NUM_PORTS)) |=> $stable(pin_sink_o));

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_lock
      // R4: locked port ignores writes
      assert_lock_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == ADDR_W'(p) && lock_q[p])
          |=> $stable(pin_sink_o[p*PORT_W +: PORT_W]));
    end
  endgenerate

  // R9: interrupt only rises after a detected edge
  assert_irq_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|hit));

  // R11: a detected edge always leaves the interrupt raised
  assert_edge_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit) |=> irq_o);
endmodule

bind dio48_port_block dio48_port_chk #(
  .NUM_PORTS(NUM_PORTS), .IRQ_PORTS(IRQ_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_wr_i   (bus_wr_i),
  .bus_addr_i (bus_addr_i),
  .pin_sink_o (pin_sink_o),
  .lock_q     (lock_q),
  .hit        (hit),
  .irq_o      (irq_o)
);

// File: tb/sim_dio48_port_block.sv
module sim_dio48_port_block;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        bus_wr_i;
  logic [3:0]  bus_addr_i;
  logic [7:0]  bus_wdata_i;
  logic [7:0]  bus_rdata_o;
  logic [47:0] ext_level;
  logic [47:0] pin_level_i;
  logic [47:0] pin_sink_o;
  logic        irq_o;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  // open-drain pin model: sunk pins read low, others follow the outside world
  assign pin_level_i = ~pin_sink_o & ext_level;

  dio48_port_block u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .pin_level_i(pin_level_i), .pin_sink_o(pin_sink_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic do_reset;
    rst_ni = 1'b0; bus_wr_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
    ext_level = '1;
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(3);
  endtask

  // {is_write, index, data (written or expected), requirement number}
  localparam int NV = 18;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 4'd0,  8'hA5, 4'd2},   // R2 write port 0
    {1'b0, 4'd0,  8'hA5, 4'd3},   // R3 sunk pins read back as 1
    {1'b1, 4'd5,  8'h3C, 4'd2},   // R2 write port 5
    {1'b0, 4'd5,  8'h3C, 4'd3},   // R3
    {1'b1, 4'd7,  8'h41, 4'd4},   // R4 page 1, lock port 0
    {1'b0, 4'd7,  8'h41, 4'd4},   // R4 readback
    {1'b1, 4'd0,  8'hFF, 4'd4},   // R4 locked write
    {1'b0, 4'd0,  8'hA5, 4'd4},   // R4 unchanged
    {1'b1, 4'd8,  8'h0F, 4'd5},   // R5 polarity port 0
    {1'b0, 4'd8,  8'h0F, 4'd5},   // R5
    {1'b1, 4'd7,  8'h80, 4'd5},   // R5 page 2
    {1'b0, 4'd8,  8'h00, 4'd5},   // R5 enable is separate
    {1'b1, 4'd9,  8'hF0, 4'd5},   // R5 enable port 1
    {1'b0, 4'd9,  8'hF0, 4'd5},   // R5
    {1'b1, 4'd7,  8'h00, 4'd5},   // R5 page 0
    {1'b0, 4'd9,  8'h00, 4'd5},   // R5 page 0 reads 0
    {1'b1, 4'd8,  8'h77, 4'd5},   // R5 page 0 write ignored
    {1'b0, 4'd6,  8'h00, 4'd8}    // R8 nothing pending
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    do_reset();

    // R1 reset state
    check("R1 sink", pin_sink_o, 48'h0);
    check("R1 irq", irq_o, 1'b0);
    rd(4'd7, d); check("R1 pagelock", d, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16]) begin
        wr(VEC[i][15:12], VEC[i][11:4]);
      end else begin
        wait_clk(3);
        rd(VEC[i][15:12], d);
        check($sformatf("R%0d vector %0d", VEC[i][3:0], i), d, VEC[i][11:4]);
      end
    end
    // R5: the page 0 write above left polarity untouched
    wr(4'd7, 8'h40); rd(4'd8, d); check("R5 pol kept", d, 8'h0F);

    // directed tests
    do_reset();
    wr(4'd0, 8'hA5);
    check("R2 sink after write", pin_sink_o[7:0], 8'hA5);
    wr(4'd0, 8'h00);
    ext_level[40] = 1'b0; wait_clk(3);
    rd(4'd5, d); check("R3 external low", d, 8'h01);
    ext_level[40] = 1'b1;

    // line 0 rising, line 1 falling, both enabled
    wr(4'd7, 8'h40); wr(4'd8, 8'h01);
    wr(4'd7, 8'h80); wr(4'd8, 8'h03);
    ext_level[0] = 1'b0; wait_clk(4);
    check("R6 wrong polarity ignored", irq_o, 1'b0);
    @(negedge clk_i); ext_level[0] = 1'b1;
    wait_clk(2);
    check("R6 not yet after two edges", irq_o, 1'b0);
    wait_clk(1);
    check("R6 rising flag on third edge", irq_o, 1'b1);
    rd(4'd6, d); check("R8 pending port 0", d, 8'h01);
    wr(4'd7, 8'hC0);
    rd(4'd8, d); check("R6 flag line 0", d, 8'h01);
    wr(4'd8, 8'h00);
    check("R10 clear drops irq", irq_o, 1'b0);
    check("R9 irq low with no flags", irq_o, 1'b0);

    ext_level[1] = 1'b0; wait_clk(3);
    rd(4'd8, d); check("R6 falling flag line 1", d, 8'h02);
    check("R9 irq high with flag", irq_o, 1'b1);
    wr(4'd8, 8'hFF);
    rd(4'd8, d); check("R10 ones keep flag", d, 8'h02);
    wr(4'd8, 8'h00);

    ext_level[2] = 1'b0; wait_clk(4); ext_level[2] = 1'b1; wait_clk(4);
    rd(4'd8, d); check("R6 disabled line silent", d, 8'h00);
    ext_level[30] = 1'b0; wait_clk(4); ext_level[30] = 1'b1; wait_clk(4);
    rd(4'd6, d); check("R7 upper line pending", d, 8'h00);
    check("R7 upper line irq", irq_o, 1'b0);

    // R11: edge detection coincides with clearing write
    ext_level[0] = 1'b0; wait_clk(4);
    @(negedge clk_i); ext_level[0] = 1'b1;
    @(posedge clk_i); @(posedge clk_i);
    @(negedge clk_i);
    bus_wr_i = 1'b1; bus_addr_i = 4'd8; bus_wdata_i = 8'h00;
    @(negedge clk_i); bus_wr_i = 1'b0;
    check("R11 irq stays", irq_o, 1'b1);
    rd(4'd8, d); check("R11 flag stays", d, 8'h01);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule